// File: doc/BRIEF.md
# Shared Crypto Core Pool Allocator

This block hands the cores of a pool of identical AES engines to two traffic directions. The receive side carries read data and does decryption. The transmit side carries write data and does encryption. Two activity inputs say whether a read block and a write block are in flight.

In the shared mode, the number of cores each side gets is looked up from four programmable 8-bit counts. The lookup key is which of the two streams is active. In the fixed mode the pool stays split in half whatever the traffic does. A core is only handed to the other side once its busy flag has dropped, so work already in progress is never taken away from its stream.

Software reaches two 32-bit registers through a plain write strobe and a combinational read port. One register selects the allocator mode. The other holds the four counts.

Top module: `crypto_pool_alloc`

## Requirements
- R1: While reset is held, and in the first cycle after it, no core is owned and both counts are zero. The mode register reads 0 (fixed mode) and the count register reads 0x0D0F1C1C (byte 0 = 28, byte 1 = 28, byte 2 = 15, byte 3 = 13).
- R2: The mode register is at address 0x260C and the count register is at 0x2664. Each reads back the last value written to it. Any other address reads 0, and writes to it change no register and no output.
- R3: When the mode register holds any value other than 2, the block is in fixed mode. Receive owns cores 0 to NUM_CORES/2-1 and transmit owns all the others, whatever the activity inputs are.
- R4: In shared mode (mode value 2), with reads active and writes idle, receive gets byte 0 of the count register and transmit gets no cores.
- R5: In shared mode, with writes active and reads idle, transmit gets byte 1 and receive gets no cores.
- R6: In shared mode, with both streams active, receive gets byte 2. Transmit gets byte 3, reduced to whatever cores receive left over if the pool cannot hold both.
- R7: In shared mode, with neither stream active, no core is owned by either stream.
- R8: Bit i of `rx_own` (or of `tx_own`) set means core i belongs to that stream. Receive fills from core 0 upward and transmit fills from core NUM_CORES-1 downward. No core is ever owned by both.
- R9: A programmed count above NUM_CORES is treated as NUM_CORES.
- R10: A core whose busy flag is high keeps its current owner. It moves to its new target in the cycle after its busy flag is seen low.
- R11: The ownership vectors and counts reflect the inputs and registers sampled at a clock edge right after that edge. Each count equals the number of set bits in its ownership vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rd_active | input | 1 | A read (receive) data block is in flight |
| wr_active | input | 1 | A write (transmit) data block is in flight |
| core_busy | input | NUM_CORES | Per-core processing flag |
| rx_own | output | NUM_CORES | Cores owned by the receive stream |
| tx_own | output | NUM_CORES | Cores owned by the transmit stream |
| rx_count | output | CNT_W | Number of receive cores |
| tx_count | output | CNT_W | Number of transmit cores |

## Verification
The four activity combinations are each driven in both modes. This shows that fixed mode ignores traffic while shared mode picks a different count byte for each case. Count values above the pool size and pairs whose sum overflows the pool show clamping apart from receive-first priority. A busy core is parked on its old stream during a read-to-write switch to separate the hold from a plain reassignment. Random traffic, random busy flags and random register writes then exercise transitions that the directed cases miss.

// File: rtl/crypto_pool_pkg.sv
// Shared definitions for the crypto core pool allocator.
// Assumes a 32-bit register port; addresses are compared on the low ADDR_W bits.
package crypto_pool_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } owner_e;

    localparam logic [31:0] ADDR_MODE    = 32'h0000_260C;
    localparam logic [31:0] ADDR_COUNTS  = 32'h0000_2664;
    localparam logic [31:0] MODE_SHARED  = 32'd2;
    localparam logic [31:0] COUNTS_RESET = 32'h0D0F_1C1C;
endpackage

// File: rtl/cpa_regs.sv
// Register file: allocator mode and packed core counts.
// Assumes single-cycle writes; reads are combinational and side-effect free.
module cpa_regs
    import crypto_pool_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              shared_en,
    output logic [31:0]       count_cfg
);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_COUNTS = ADDR_W'(ADDR_COUNTS);

    logic [31:0] mode_q;

    // Capture register writes; reset loads fixed mode and default counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            count_cfg <= COUNTS_RESET;
        end else if (reg_wen) begin
            if (reg_addr == A_MODE)   mode_q    <= reg_wdata;
            if (reg_addr == A_COUNTS) count_cfg <= reg_wdata;
        end
    end

    // Return the addressed register, zero elsewhere.
    always_comb begin
        if (reg_addr == A_MODE)        reg_rdata = mode_q;
        else if (reg_addr == A_COUNTS) reg_rdata = count_cfg;
        else                           reg_rdata = '0;
    end

    assign shared_en = (mode_q == MODE_SHARED);
endmodule

// File: rtl/cpa_split.sv
// Target split: picks the RX and TX core counts for the current traffic.
// Assumes NUM_CORES <= 255 so an 8-bit count can express the whole pool.
module cpa_split #(
    parameter int NUM_CORES = 28,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic             shared_en,
    input  logic [31:0]      count_cfg,
    input  logic             rd_active,
    input  logic             wr_active,
    output logic [CNT_W-1:0] rx_tgt,
    output logic [CNT_W-1:0] tx_tgt
);
    localparam logic [CNT_W-1:0] POOL    = CNT_W'(NUM_CORES);
    localparam logic [CNT_W-1:0] HALF_RX = CNT_W'(NUM_CORES / 2);

    function automatic logic [CNT_W-1:0] clamp(input logic [7:0] c);
        if (c > 8'(NUM_CORES)) return POOL;
        return CNT_W'(c);
    endfunction

    logic [CNT_W-1:0] dual_rx, dual_tx, room;

    // Both-active split: RX first, TX limited to what remains.
    always_comb begin
        dual_rx = clamp(count_cfg[23:16]);
        room    = POOL - dual_rx;
        dual_tx = clamp(count_cfg[31:24]);
        if (dual_tx > room) dual_tx = room;
    end

    // Select the split from the mode and the activity pair.
    always_comb begin
        rx_tgt = '0;
        tx_tgt = '0;
        if (!shared_en) begin
            rx_tgt = HALF_RX;
            tx_tgt = POOL - HALF_RX;
        end else begin
            case ({rd_active, wr_active})
                2'b10:   rx_tgt = clamp(count_cfg[7:0]);
                2'b01:   tx_tgt = clamp(count_cfg[15:8]);
                2'b11: begin
                    rx_tgt = dual_rx;
                    tx_tgt = dual_tx;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpa_owner.sv
// Per-core ownership registers with busy handshake, plus registered counts.
// Assumes rx_tgt + tx_tgt <= NUM_CORES so the two target regions never overlap.
module cpa_owner
    import crypto_pool_pkg::*;
#(
    parameter int NUM_CORES = 28,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     rx_tgt,
    input  logic [CNT_W-1:0]     tx_tgt,
    input  logic [NUM_CORES-1:0] core_busy,
    output logic [NUM_CORES-1:0] rx_own,
    output logic [NUM_CORES-1:0] tx_own,
    output logic [CNT_W-1:0]     rx_count,
    output logic [CNT_W-1:0]     tx_count
);
    localparam logic [CNT_W-1:0] POOL = CNT_W'(NUM_CORES);

    logic [CNT_W-1:0]     tx_base;
    logic [NUM_CORES-1:0] rx_nxt, tx_nxt;

    assign tx_base = POOL - tx_tgt;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        owner_e cur_q, tgt, nxt;

        // Target owner of this core from the contiguous region layout.
        always_comb begin
            if (CNT_W'(i) < rx_tgt)        tgt = OWN_RX;
            else if (CNT_W'(i) >= tx_base) tgt = OWN_TX;
            else                           tgt = OWN_NONE;
        end

        // Hold a busy owned core on its stream, otherwise follow the target.
        always_comb begin
            if (cur_q != tgt && cur_q != OWN_NONE && core_busy[i]) nxt = cur_q;
            else                                                   nxt = tgt;
        end

        // Ownership state of this core.
        always_ff @(posedge clk) begin
            if (!rst_n) cur_q <= OWN_NONE;
            else        cur_q <= nxt;
        end

        assign rx_nxt[i] = (nxt == OWN_RX);
        assign tx_nxt[i] = (nxt == OWN_TX);
        assign rx_own[i] = (cur_q == OWN_RX);
        assign tx_own[i] = (cur_q == OWN_TX);
    end

    logic [CNT_W-1:0] rx_sum, tx_sum;

    // Population counts of the next ownership vectors.
    always_comb begin
        rx_sum = '0;
        tx_sum = '0;
        for (int k = 0; k < NUM_CORES; k++) begin
            rx_sum = rx_sum + CNT_W'(rx_nxt[k]);
            tx_sum = tx_sum + CNT_W'(tx_nxt[k]);
        end
    end

    // Register the counts alongside the ownership state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_count <= '0;
            tx_count <= '0;
        end else begin
            rx_count <= rx_sum;
            tx_count <= tx_sum;
        end
    end
endmodule

// File: rtl/crypto_pool_alloc.sv
// Top: divides a pool of AES cores between the RX and TX streams.
// Assumes activity and busy inputs are synchronous to clk.
module crypto_pool_alloc #(
    parameter int NUM_CORES = 28,
    parameter int ADDR_W    = 16,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wen,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 rd_active,
    input  logic                 wr_active,
    input  logic [NUM_CORES-1:0] core_busy,
    output logic [NUM_CORES-1:0] rx_own,
    output logic [NUM_CORES-1:0] tx_own,
    output logic [CNT_W-1:0]     rx_count,
    output logic [CNT_W-1:0]     tx_count
);
    logic             shared_en;
    logic [31:0]      count_cfg;
    logic [CNT_W-1:0] rx_tgt, tx_tgt;

    cpa_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .shared_en (shared_en),
        .count_cfg (count_cfg)
    );

    cpa_split #(.NUM_CORES(NUM_CORES)) u_split (
        .shared_en (shared_en),
        .count_cfg (count_cfg),
        .rd_active (rd_active),
        .wr_active (wr_active),
        .rx_tgt    (rx_tgt),
        .tx_tgt    (tx_tgt)
    );

    cpa_owner #(.NUM_CORES(NUM_CORES)) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_tgt    (rx_tgt),
        .tx_tgt    (tx_tgt),
        .core_busy (core_busy),
        .rx_own    (rx_own),
        .tx_own    (tx_own),
        .rx_count  (rx_count),
        .tx_count  (tx_count)
    );
endmodule

// File: rtl/crypto_pool_alloc_chk.sv
// Checker for the pool allocator, bound to the top module.
// Assumes it observes the top's ports and its mode/count register outputs.
module crypto_pool_alloc_chk #(
    parameter int NUM_CORES = 28,
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shared_en,
    input logic [31:0]          count_cfg,
    input logic                 rd_active,
    input logic                 wr_active,
    input logic [NUM_CORES-1:0] core_busy,
    input logic [NUM_CORES-1:0] rx_own,
    input logic [NUM_CORES-1:0] tx_own,
    input logic [CNT_W-1:0]     rx_count,
    input logic [CNT_W-1:0]     tx_count
);
    assert_no_double_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_own & tx_own) == '0);

    assert_pool_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rx_count} + {1'b0, tx_count}) <= (CNT_W + 1)'(NUM_CORES));

    assert_fixed_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shared_en && core_busy == '0) |=>
        (rx_count == CNT_W'(NUM_CORES / 2) && tx_count == CNT_W'(NUM_CORES - NUM_CORES / 2)));

    assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_en && !rd_active && !wr_active && core_busy == '0) |=>
        (rx_count == '0 && tx_count == '0));

    assert_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_en && rd_active && !wr_active && core_busy == '0) |=>
        (tx_count == '0 && rx_count == (($past(count_cfg[7:0]) > 8'(NUM_CORES)) ?
            CNT_W'(NUM_CORES) : CNT_W'($past(count_cfg[7:0])))));

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_hold
        assert_busy_keeps_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_own[i] && core_busy[i]) |=> rx_own[i]);
        assert_busy_keeps_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_own[i] && core_busy[i]) |=> tx_own[i]);
    end
endmodule

bind crypto_pool_alloc crypto_pool_alloc_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shared_en (shared_en),
    .count_cfg (count_cfg),
    .rd_active (rd_active),
    .wr_active (wr_active),
    .core_busy (core_busy),
    .rx_own    (rx_own),
    .tx_own    (tx_own),
    .rx_count  (rx_count),
    .tx_count  (tx_count)
);

// File: tb/crypto_pool_alloc_tb.sv
`timescale 1ns/1ps
module crypto_pool_alloc_tb;
    localparam int N  = 28;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wen;
    logic [15:0]   reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          rd_active, wr_active;
    logic [N-1:0]  core_busy;
    logic [N-1:0]  rx_own, tx_own;
    logic [CW-1:0] rx_count, tx_count;

    int checks = 0;
    int errors = 0;

    // Bench model state: 0 none, 1 RX, 2 TX.
    int          m_own [N];
    logic [31:0] m_mode, m_cnt;

    always #2 clk = ~clk;

    crypto_pool_alloc #(.NUM_CORES(N), .ADDR_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_active(rd_active),
        .wr_active(wr_active), .core_busy(core_busy), .rx_own(rx_own),
        .tx_own(tx_own), .rx_count(rx_count), .tx_count(tx_count)
    );

    function automatic int clampc(input int c);
        return (c > N) ? N : c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs present at that edge.
    task automatic model_edge();
        int rx, tx, tgt;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_own[i] = 0;
            m_mode = 32'd0;
            m_cnt  = 32'h0D0F_1C1C;
            return;
        end
        rx = 0; tx = 0;
        if (m_mode != 32'd2) begin
            rx = N / 2; tx = N - N / 2;
        end else if (rd_active && !wr_active) begin
            rx = clampc(int'(m_cnt[7:0]));
        end else if (!rd_active && wr_active) begin
            tx = clampc(int'(m_cnt[15:8]));
        end else if (rd_active && wr_active) begin
            rx = clampc(int'(m_cnt[23:16]));
            tx = clampc(int'(m_cnt[31:24]));
            if (tx > N - rx) tx = N - rx;
        end
        for (int i = 0; i < N; i++) begin
            tgt = (i < rx) ? 1 : ((i >= N - tx) ? 2 : 0);
            if (!(m_own[i] != tgt && m_own[i] != 0 && core_busy[i])) m_own[i] = tgt;
        end
        if (reg_wen && reg_addr == 16'h260C) m_mode = reg_wdata;
        if (reg_wen && reg_addr == 16'h2664) m_cnt  = reg_wdata;
    endtask

    task automatic check_model(input string tag);
        logic [N-1:0] erx, etx;
        erx = '0; etx = '0;
        for (int i = 0; i < N; i++) begin
            erx[i] = (m_own[i] == 1);
            etx[i] = (m_own[i] == 2);
        end
        check({tag, " rx_own"},   32'(rx_own),   32'(erx));
        check({tag, " tx_own"},   32'(tx_own),   32'(etx));
        check({tag, " rx_count"}, 32'(rx_count), 32'($countones(erx)));
        check({tag, " tx_count"}, 32'(tx_count), 32'($countones(etx)));
    endtask

    // One clock: model follows the edge, outputs checked 1 ns later (R11).
    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        check_model("R11");
        reg_wen = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
    endtask

    task automatic rd_check(input string tag, input logic [15:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        check(tag, reg_rdata, exp);
    endtask

    task automatic traffic(input logic r, input logic w, input logic [N-1:0] b);
        rd_active = r; wr_active = w; core_busy = b;
        tick();
    endtask

    // Watchdog: a hung run is one failed check, then the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
        rd_active = 1'b0; wr_active = 1'b0; core_busy = '0;
        tick(); tick();
        // R1: reset state.
        check("R1 rx_own", 32'(rx_own), 32'h0);
        check("R1 rx_count", 32'(rx_count), 32'h0);
        rd_check("R1 mode", 16'h260C, 32'h0);
        rd_check("R1 counts", 16'h2664, 32'h0D0F_1C1C);
        #0.5; rst_n = 1'b1;

        // R3: fixed split, unaffected by traffic.
        traffic(1'b1, 1'b0, '0);
        check("R3 rx_own", 32'(rx_own), 32'h0003FFF);
        check("R3 tx_own", 32'(tx_own), 32'h0FFFC000);
        traffic(1'b0, 1'b1, '0);
        check("R3 rx_own wr", 32'(rx_own), 32'h0003FFF);

        // R2: register map and unmapped address.
        wr(16'h260C, 32'd2);
        rd_check("R2 mode", 16'h260C, 32'd2);
        wr(16'h1234, 32'hFFFF_FFFF);
        rd_check("R2 unmapped", 16'h1234, 32'h0);
        rd_check("R2 counts kept", 16'h2664, 32'h0D0F_1C1C);

        // R5: write only.
        traffic(1'b0, 1'b1, '0);
        check("R5 tx_count", 32'(tx_count), 32'd28);
        check("R5 rx_count", 32'(rx_count), 32'd0);
        // R6 / R8: both active with defaults.
        traffic(1'b1, 1'b1, '0);
        check("R6 rx_own", 32'(rx_own), 32'h0007FFF);
        check("R8 tx_own", 32'(tx_own), 32'h0FFF8000);
        // R7: idle.
        traffic(1'b0, 1'b0, '0);
        check("R7 rx_own", 32'(rx_own), 32'h0);
        check("R7 tx_own", 32'(tx_own), 32'h0);

        // R9 / R6: clamp and RX-first priority (b0=48, b1=9, b2=20, b3=20).
        wr(16'h2664, 32'h1414_0930);
        traffic(1'b1, 1'b0, '0);
        check("R9 rx_count", 32'(rx_count), 32'd28);
        check("R4 tx_count", 32'(tx_count), 32'd0);
        traffic(1'b1, 1'b1, '0);
        check("R6 rx_count", 32'(rx_count), 32'd20);
        check("R6 tx_count", 32'(tx_count), 32'd8);

        // R10: busy core 27 stays RX through a read-to-write switch.
        traffic(1'b1, 1'b0, '0);
        traffic(1'b0, 1'b1, 28'h8000000);
        check("R10 rx_own held", 32'(rx_own), 32'h8000000);
        check("R10 tx_count", 32'(tx_count), 32'd8);
        traffic(1'b0, 1'b1, 28'h8000000);
        check("R10 still held", 32'(rx_count), 32'd1);
        traffic(1'b0, 1'b1, '0);
        check("R10 released", 32'(rx_own), 32'h0);

        // Random traffic, busy flags and register writes.
        for (int n = 0; n < 600; n++) begin
            logic [31:0] v;
            v = $urandom;
            rd_active = v[0]; wr_active = v[1];
            core_busy = (v[4:2] == 3'd0) ? N'($urandom & $urandom) : '0;
            if (v[9:7] == 3'd0) begin
                wr(16'h2664, {8'($urandom % 40), 8'($urandom % 40),
                              8'($urandom % 40), 8'($urandom % 40)});
            end else if (v[12:10] == 3'd0) begin
                wr(16'h260C, (v[13]) ? 32'd2 : 32'($urandom % 4));
            end else begin
                tick();
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule